// File: doc/BRIEF.md
# Smart Panel Parallel Command and Data Bus Engine

This block lets a host move single words between itself and one of two smart display panels over an 8080-style parallel bus. The host stages a 32-bit word, then writes a go register. The block drives the chip selects, the register-select line and the write or read strobe with fixed timing. Busy is reported in a status register.

Every staged word carries two flags. One marks the word as a genuine write request. The other chooses between an index (command) cycle and a data cycle. For a read, the host first arms the engine through the read-data register and then writes the read-go register. The panel's answer is captured when the read strobe rises and is returned as an 18-bit value.

Each go write names its target panel in one bit, which picks one of the two active-low chip selects. Pixel streaming, DMA and clock generation belong to other blocks.

Top module: `pbus_engine`

## Requirements
- R1: After reset all chip selects, the write strobe and the read strobe are high (inactive), the status busy bit (bit 1, address 4) reads 0, and the read-data register (address 2) reads 0.
- R2: A host write to the write-go register (address 1) with bit 0 set starts exactly one write cycle, but only if bit 28 of the staged word (address 0) is set. A go value with bit 0 clear, or a staged word with bit 28 clear, starts nothing.
- R3: During a write cycle, the register-select line equals bit 24 of the staged word (1 = data, 0 = index), and the data lines carry the low 18 bits of the staged word.
- R4: Bit 1 of the go value selects the panel: 0 drives chip select 0 low (main) and 1 drives chip select 1 low (sub). At most one chip select is ever low.
- R5: Chip select and register-select settle one clock before the strobe falls and stay stable while it is low. The strobe stays low for exactly STROBE_CYC clocks (default 2).
- R6: The status busy bit reads 1 from the clock after an accepted go until one clock after the strobe rises, a total of STROBE_CYC+2 clocks. A chip select is low only while busy.
- R7: Writing the read-data register with bit 24 set arms a read. A read-go write (address 3) with bit 0 set then runs one read cycle with register-select at 1, and the arm is used up. A read-go while unarmed starts nothing.
- R8: The panel input is sampled on the clock at which the read strobe rises. The read-data register then returns that value in bits 17:0, with bits 31:18 reading 0.
- R9: While busy, host writes to the staged word and to either go register are ignored. The staged word keeps its value and no extra cycle follows.
- R10: The write and read strobes are never low together, and the data drivers are enabled only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address (0 staged word, 1 write go, 2 read data, 3 read go, 4 status) |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Read value of the register at host_addr |
| panel_cs_n | output | 2 | Active-low chip selects, bit 0 main panel, bit 1 sub panel |
| panel_rs | output | 1 | Register-select, 1 = data, 0 = index |
| panel_wr_n | output | 1 | Active-low write strobe |
| panel_rd_n | output | 1 | Active-low read strobe |
| panel_oe | output | 1 | Output enable for the data lines |
| panel_dout | output | 18 | Data driven to the panel |
| panel_din | input | 18 | Data returned from the panel |

## Verification
A corrupted sequencer state shows at the panel pins within the same transfer. The strobe may be too short or too long, it may fall without a settled chip select, or busy may linger or end early. Any of these is caught when the strobe rises or when the status poll completes. A wrong panel latch or register-select latch appears as a mismatched chip select or register-select on the very first strobe clock. A lost arm or a stale capture appears at the first read-data readback after a read cycle. A staged word that changes while busy appears at the next readback of address 0.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned HOST_AW = 3;
  localparam logic [HOST_AW-1:0] A_WSTAGE = 3'd0;
  localparam logic [HOST_AW-1:0] A_WGO    = 3'd1;
  localparam logic [HOST_AW-1:0] A_RDATA  = 3'd2;
  localparam logic [HOST_AW-1:0] A_RGO    = 3'd3;
  localparam logic [HOST_AW-1:0] A_STATUS = 3'd4;
  localparam int unsigned VALID_BIT = 28;
  localparam int unsigned KIND_BIT  = 24;
  localparam int unsigned ARM_BIT   = 24;
  localparam int unsigned GO_BIT    = 0;
  localparam int unsigned PSEL_BIT  = 1;
  localparam int unsigned BUSY_BIT  = 1;
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_DONE} seq_state_t;
endpackage

// File: rtl/pbus_regs.sv
module pbus_regs
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               busy,
  input  logic               cap_en,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [31:0]        staged,
  output logic               start_wr,
  output logic               start_rd,
  output logic               sel
);
  logic [31:0]       staged_q;
  logic              arm_q, arm_d;
  logic [DATA_W-1:0] cap_q;
  logic              staged_en, arm_wr;

  always_comb begin
    staged_en = host_we && (host_addr == A_WSTAGE) && !busy;
    arm_wr    = host_we && (host_addr == A_RDATA) && !busy;
    start_wr  = host_we && (host_addr == A_WGO) && host_wdata[GO_BIT]
                && !busy && staged_q[VALID_BIT];
    start_rd  = host_we && (host_addr == A_RGO) && host_wdata[GO_BIT]
                && !busy && arm_q;
    sel       = host_wdata[PSEL_BIT];
    arm_d     = arm_q;
    if (start_rd)    arm_d = 1'b0;
    else if (arm_wr) arm_d = host_wdata[ARM_BIT];
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_WSTAGE: host_rdata = staged_q;
      A_RDATA:  host_rdata[DATA_W-1:0] = cap_q;
      A_STATUS: host_rdata[BUSY_BIT] = busy;
      default:  host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      arm_q    <= 1'b0;
      cap_q    <= '0;
    end else begin
      if (staged_en) staged_q <= host_wdata;
      arm_q <= arm_d;
      if (cap_en) cap_q <= cap_data;
    end
  end

  assign staged = staged_q;
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic       start_rd,
  input  logic       sel,
  input  logic       stage_rs,
  output logic       busy,
  output logic [1:0] cs_n,
  output logic       rs,
  output logic       wr_n,
  output logic       rd_n,
  output logic       oe,
  output logic       cap_en
);
  localparam int unsigned CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d, sel_q, sel_d, rs_q, rs_d;
  logic             in_act, last_act;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    sel_d   = sel_q;
    rs_d    = rs_q;
    case (state_q)
      S_IDLE: if (start_wr || start_rd) begin
        state_d = S_SETUP;
        rd_d    = start_rd;
        sel_d   = sel;
        rs_d    = start_rd ? 1'b1 : stage_rs;
      end
      S_SETUP: begin
        state_d = S_ACT;
        cnt_d   = CNT_LOAD;
      end
      S_ACT: begin
        if (cnt_q == '0) state_d = S_DONE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      sel_q   <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      sel_q   <= sel_d;
      rs_q    <= rs_d;
    end
  end

  always_comb begin
    busy     = (state_q != S_IDLE);
    in_act   = (state_q == S_ACT);
    last_act = in_act && (cnt_q == '0);
    cs_n     = 2'b11;
    if (busy) cs_n[sel_q] = 1'b0;
    rs       = busy ? rs_q : 1'b0;
    wr_n     = !(in_act && !rd_q);
    rd_n     = !(in_act && rd_q);
    oe       = busy && !rd_q;
    cap_en   = last_act && rd_q;
  end
endmodule

// File: rtl/pbus_engine.sv
module pbus_engine
  import pbus_pkg::*;
#(
  parameter int unsigned DATA_W     = 18,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic [1:0]         panel_cs_n,
  output logic               panel_rs,
  output logic               panel_wr_n,
  output logic               panel_rd_n,
  output logic               panel_oe,
  output logic [DATA_W-1:0]  panel_dout,
  input  logic [DATA_W-1:0]  panel_din
);
  logic [1:0]  rst_sync_q;
  logic        rst_core_n;
  logic        busy_w, cap_en_w, start_wr_w, start_rd_w, sel_w;
  logic [31:0] staged_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pbus_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy_w),
    .cap_en(cap_en_w), .cap_data(panel_din), .staged(staged_w),
    .start_wr(start_wr_w), .start_rd(start_rd_w), .sel(sel_w)
  );

  pbus_seq #(.STROBE_CYC(STROBE_CYC)) seq_i (
    .clk(clk), .rst_n(rst_core_n), .start_wr(start_wr_w), .start_rd(start_rd_w),
    .sel(sel_w), .stage_rs(staged_w[KIND_BIT]), .busy(busy_w), .cs_n(panel_cs_n),
    .rs(panel_rs), .wr_n(panel_wr_n), .rd_n(panel_rd_n), .oe(panel_oe),
    .cap_en(cap_en_w)
  );

  assign panel_dout = panel_oe ? staged_w[DATA_W-1:0] : '0;
endmodule

// File: rtl/pbus_engine_chk.sv
module pbus_engine_chk
  import pbus_pkg::*;
#(
  parameter int unsigned STROBE_CYC = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic [1:0]         cs_n,
  input logic               rs,
  input logic               wr_n,
  input logic               rd_n,
  input logic               oe,
  input logic [31:0]        staged
);
  logic [15:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (!wr_n || !rd_n) low_cnt <= low_cnt + 1'b1;
    else                     low_cnt <= '0;
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  p_oe_write_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rd_n);
  p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n) || $fell(rd_n)) |-> ($stable(cs_n) && $stable(rs) && cs_n != 2'b11));
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt != '0 && wr_n && rd_n) |-> (low_cnt == 16'(STROBE_CYC)));
  p_cs_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11) |-> busy);
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(staged));
endmodule

bind pbus_engine pbus_engine_chk #(.STROBE_CYC(STROBE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .cs_n(panel_cs_n), .rs(panel_rs),
  .wr_n(panel_wr_n), .rd_n(panel_rd_n), .oe(panel_oe), .staged(staged_w)
);

// File: tb/pbus_engine_tb_top.sv
module pbus_engine_tb_top;
  localparam int DW = 18;
  localparam int SC = 2;

  typedef struct packed {
    logic          rd;
    logic [1:0]    cs;
    logic          rs;
    logic [DW-1:0] data;
    logic [7:0]    low;
  } xfer_t;

  logic          clk, rst_n, host_we;
  logic [2:0]    host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic [1:0]    panel_cs_n;
  logic          panel_rs, panel_wr_n, panel_rd_n, panel_oe;
  logic [DW-1:0] panel_dout, panel_din;

  int checks = 0;
  int errors = 0;
  xfer_t exp_q[$];
  bit done = 0;

  pbus_engine #(.DATA_W(DW), .STROBE_CYC(SC)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: collects each completed strobe and compares with the scoreboard
  logic [1:0]    prev_cs;
  logic          prev_rs, in_low, setup_ok;
  xfer_t         obs;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!panel_wr_n || !panel_rd_n) begin
        if (!in_low) begin
          in_low   = 1'b1;
          obs.rd   = !panel_rd_n;
          obs.cs   = panel_cs_n;
          obs.rs   = panel_rs;
          obs.data = panel_dout;
          obs.low  = 8'd1;
          setup_ok = (prev_cs == panel_cs_n) && (prev_rs == panel_rs) && (panel_cs_n != 2'b11);
        end else obs.low = obs.low + 8'd1;
      end else if (in_low) begin
        in_low = 1'b0;
        if (exp_q.size() == 0) begin
          chk("R2 R9 unexpected cycle", 32'(obs.cs), 32'h3);
        end else begin
          xfer_t e;
          e = exp_q.pop_front();
          chk("R7 cycle kind", 32'(obs.rd), 32'(e.rd));
          chk("R4 chip select", 32'(obs.cs), 32'(e.cs));
          chk("R3 register-select", 32'(obs.rs), 32'(e.rs));
          chk("R3 data lines", 32'(obs.data), 32'(e.data));
          chk("R5 strobe width", 32'(obs.low), 32'(e.low));
          chk("R5 setup before strobe", 32'(setup_ok), 32'd1);
        end
      end
      prev_cs = panel_cs_n;
      prev_rs = panel_rs;
    end else begin
      in_low = 1'b0;
      prev_cs = 2'b11;
      prev_rs = 1'b0;
    end
  end

  task automatic host_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(logic [2:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic count_busy(output int n);
    logic [31:0] s;
    n = 0;
    forever begin
      host_read(3'd4, s);
      if (!s[1]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic push(logic rd, logic sel, logic rs, logic [DW-1:0] d);
    xfer_t e;
    e.rd = rd; e.cs = sel ? 2'b01 : 2'b10; e.rs = rs;
    e.data = rd ? '0 : d; e.low = 8'(SC);
    exp_q.push_back(e);
  endtask

  task automatic do_write(logic [31:0] w, logic sel);
    int n;
    host_write(3'd0, w);
    if (w[28]) push(1'b0, sel, w[24], w[DW-1:0]);
    host_write(3'd1, {30'd0, sel, 1'b1});
    count_busy(n);
    chk("R6 busy length", 32'(n), w[28] ? 32'(SC + 2) : 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    int n;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; panel_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 chip selects", 32'(panel_cs_n), 32'h3);
    chk("R1 strobes", {30'd0, panel_wr_n, panel_rd_n}, 32'h3);
    host_read(3'd4, r); chk("R1 busy", r, 32'd0);
    host_read(3'd2, r); chk("R1 read data", r, 32'd0);

    // R2 R3 R4: index write to main, data write to sub
    do_write(32'h1000_0A5C, 1'b0);
    do_write(32'h1103_1234, 1'b1);
    do_write(32'h1101_FFFF, 1'b0);

    // R2: no valid flag, and go without bit 0
    do_write(32'h0100_0077, 1'b0);
    host_write(3'd0, 32'h1100_0055);
    host_write(3'd1, 32'h0000_0002);
    host_read(3'd4, r); chk("R2 go bit clear", r, 32'd0);

    // R9: writes while busy are ignored
    host_write(3'd0, 32'h1000_0321);
    push(1'b0, 1'b1, 1'b0, 18'h00321);
    host_write(3'd1, 32'h3);
    host_write(3'd0, 32'h1100_0999);
    host_write(3'd1, 32'h1);
    count_busy(n);
    host_read(3'd0, r); chk("R9 staged word kept", r, 32'h1000_0321);
    repeat (3) @(negedge clk);
    chk("R9 no extra cycle", 32'(exp_q.size()), 32'd0);

    // R7 R8: armed read from sub, then main
    panel_din = 18'h2ABCD;
    host_write(3'd2, 32'h0100_0000);
    push(1'b1, 1'b1, 1'b1, '0);
    host_write(3'd3, 32'h3);
    count_busy(n); chk("R6 read busy length", 32'(n), 32'(SC + 2));
    host_read(3'd2, r); chk("R8 capture", r, 32'h0002_ABCD);
    panel_din = 18'h15432;
    host_write(3'd2, 32'hFF00_0000);
    push(1'b1, 1'b0, 1'b1, '0);
    host_write(3'd3, 32'h1);
    count_busy(n);
    host_read(3'd2, r); chk("R8 capture upper zero", r, 32'h0001_5432);

    // R7: arm used up, read-go now ignored
    panel_din = 18'h00FFF;
    host_write(3'd3, 32'h1);
    host_read(3'd4, r); chk("R7 unarmed go", r, 32'd0);
    host_read(3'd2, r); chk("R7 capture unchanged", r, 32'h0001_5432);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule